// File: doc/BRIEF.md
# GPIO Bank with Edge-Event Capture

This block is a bank of general-purpose pins. Each pin can be taken over from its native function through a claim bit. Once claimed, it acts as a software-driven output or a sampled input. Software reaches a set of register vectors through a simple write strobe, a 3-bit register select and a combinational read port. Each vector holds one bit per pin.

Input pins pass through a two-stage synchronizer. Rising and falling transitions can each be armed per pin. An armed transition on a claimed input sets a sticky per-pin status bit, and software clears that bit by writing a one. Any set status bit raises the event output. Some pins sit in the standby power domain, and the `STBY_PINS` parameter marks which ones. For those pins only, a wake-arm bit routes the status bit to the wake output as well.

The reset input is asserted asynchronously and released through a two-flop synchronizer.

Top module: `gpio_evt_bank`

## Requirements
- R1: After reset every register vector reads 0, `evt_o` and `wake_o` are 0, and `pad_out`/`pad_oe` equal `fn_out`/`fn_oe`.
- R2: A pin whose claim bit (select 0) is 0 passes `fn_out`/`fn_oe` to its pad, and never sets its status bit, whatever its other bits hold.
- R3: The direction bit (select 1) is 1 for input and 0 for output. A claimed output pin has `pad_oe`=1 and drives the level bit (select 2) on `pad_out`.
- R4: A claimed input pin has `pad_oe`=0 and `pad_out`=0.
- R5: Reading select 2 returns the synchronized pad input for pins whose direction bit is 1, and the written level bit for the other pins.
- R6: On a claimed input with its rise-arm bit (select 3) set, a 0-to-1 pad transition sets its status bit (select 5) within 4 clock cycles.
- R7: On a claimed input with its fall-arm bit (select 4) set, a 1-to-0 pad transition sets its status bit within 4 clock cycles. A transition whose arm bit is clear sets nothing.
- R8: A pin configured as output never sets its status bit.
- R9: Status bits are sticky. Writing 1 to a bit at select 5 clears it, and writing 0 leaves it unchanged.
- R10: When an armed transition is detected in the same cycle as a clear write to that bit, the bit remains set.
- R11: `evt_o` is 1 exactly when at least one status bit is set.
- R12: The wake-arm vector (select 6) holds bits only for pins marked in `STBY_PINS` and reads 0 elsewhere. `wake_o` is the OR of the status bits whose wake-arm bit is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 3 | Register vector select |
| cfg_wdata | input | NUM_PINS | Write data, one bit per pin |
| cfg_rdata | output | NUM_PINS | Read data for the selected vector |
| pad_in | input | NUM_PINS | Pad input levels (asynchronous) |
| fn_out | input | NUM_PINS | Native-function output values |
| fn_oe | input | NUM_PINS | Native-function output enables |
| pad_out | output | NUM_PINS | Pad output values |
| pad_oe | output | NUM_PINS | Pad output enables |
| evt_o | output | 1 | General-purpose event |
| wake_o | output | 1 | Wake request |

## Verification
The hardest case to reach is an armed transition that lands in exactly the cycle in which software writes a clear to the same status bit. The bench first sets the bit with one transition. It then drives the opposite transition and counts the two synchronizer stages. It issues the clear write at the edge where the comparison stage sees the change, and then reads the bit back. The rest of the bench sweeps every claim, direction and arm combination on every pin, for both transition directions.

// File: rtl/gpio_evt_pkg.sv
package gpio_evt_pkg;
  localparam int SEL_W = 3;

  typedef enum logic [SEL_W-1:0] {
    SEL_CLAIM = 3'd0,
    SEL_DIR   = 3'd1,
    SEL_LEVEL = 3'd2,
    SEL_RISE  = 3'd3,
    SEL_FALL  = 3'd4,
    SEL_STAT  = 3'd5,
    SEL_WAKE  = 3'd6
  } cfg_sel_e;
endpackage

// File: rtl/gpio_rst_sync.sv
module gpio_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_n_sync = stage_q[1];
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] pad_i,
  output logic [WIDTH-1:0] sync_o,
  output logic [WIDTH-1:0] rise_o,
  output logic [WIDTH-1:0] fall_o
);
  logic [WIDTH-1:0] meta_q, sync_q, prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= pad_i;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  assign sync_o = sync_q;
  assign rise_o = sync_q & ~prev_q;
  assign fall_o = ~sync_q & prev_q;
endmodule

// File: rtl/gpio_edge_capture.sv
module gpio_edge_capture #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] arm_i,
  input  logic [WIDTH-1:0] rise_en_i,
  input  logic [WIDTH-1:0] fall_en_i,
  input  logic [WIDTH-1:0] rise_i,
  input  logic [WIDTH-1:0] fall_i,
  input  logic [WIDTH-1:0] clr_i,
  output logic [WIDTH-1:0] stat_o
);
  logic [WIDTH-1:0] stat_q, stat_d, hit;

  always_comb begin
    hit    = arm_i & ((rise_en_i & rise_i) | (fall_en_i & fall_i));
    stat_d = (stat_q & ~clr_i) | hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_q <= '0;
    else        stat_q <= stat_d;
  end

  assign stat_o = stat_q;

  for (genvar i = 0; i < WIDTH; i++) begin : g_chk
    AST_STAT_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(stat_q[i]) |-> $past(arm_i[i] && (rise_en_i[i] || fall_en_i[i]))); // R8
    AST_STAT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_q[i] && !clr_i[i]) |=> stat_q[i]); // R9
    AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (hit[i] && clr_i[i]) |=> stat_q[i]); // R10
  end
endmodule

// File: rtl/gpio_evt_bank.sv
module gpio_evt_bank
  import gpio_evt_pkg::*;
#(
  parameter int                  NUM_PINS  = 8,
  parameter logic [NUM_PINS-1:0] STBY_PINS = 8'hF0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_we,
  input  logic [SEL_W-1:0]    cfg_sel,
  input  logic [NUM_PINS-1:0] cfg_wdata,
  output logic [NUM_PINS-1:0] cfg_rdata,
  input  logic [NUM_PINS-1:0] pad_in,
  input  logic [NUM_PINS-1:0] fn_out,
  input  logic [NUM_PINS-1:0] fn_oe,
  output logic [NUM_PINS-1:0] pad_out,
  output logic [NUM_PINS-1:0] pad_oe,
  output logic                evt_o,
  output logic                wake_o
);
  localparam int W = NUM_PINS;

  logic         rst_n_sync;
  logic [W-1:0] claim_q, dir_q, lvl_q, rise_q, fall_q, wake_q;
  logic [W-1:0] claim_d, dir_d, lvl_d, rise_d, fall_d, wake_d;
  logic [W-1:0] sync_in, rise_det, fall_det, stat, clr, arm, gpio_oe;

  gpio_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  gpio_in_sync #(.WIDTH(W)) u_in_sync (
    .clk    (clk),
    .rst_n  (rst_n_sync),
    .pad_i  (pad_in),
    .sync_o (sync_in),
    .rise_o (rise_det),
    .fall_o (fall_det)
  );

  // Next-state for the configuration vectors
  always_comb begin
    claim_d = claim_q;
    dir_d   = dir_q;
    lvl_d   = lvl_q;
    rise_d  = rise_q;
    fall_d  = fall_q;
    wake_d  = wake_q;
    clr     = '0;
    if (cfg_we) begin
      case (cfg_sel)
        SEL_CLAIM: claim_d = cfg_wdata;
        SEL_DIR:   dir_d   = cfg_wdata;
        SEL_LEVEL: lvl_d   = cfg_wdata;
        SEL_RISE:  rise_d  = cfg_wdata;
        SEL_FALL:  fall_d  = cfg_wdata;
        SEL_STAT:  clr     = cfg_wdata;
        SEL_WAKE:  wake_d  = cfg_wdata & STBY_PINS;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n_sync) begin
    if (!rst_n_sync) begin
      claim_q <= '0;
      dir_q   <= '0;
      lvl_q   <= '0;
      rise_q  <= '0;
      fall_q  <= '0;
      wake_q  <= '0;
    end else if (cfg_we) begin
      claim_q <= claim_d;
      dir_q   <= dir_d;
      lvl_q   <= lvl_d;
      rise_q  <= rise_d;
      fall_q  <= fall_d;
      wake_q  <= wake_d;
    end
  end

  assign arm = claim_q & dir_q;

  gpio_edge_capture #(.WIDTH(W)) u_capture (
    .clk       (clk),
    .rst_n     (rst_n_sync),
    .arm_i     (arm),
    .rise_en_i (rise_q),
    .fall_en_i (fall_q),
    .rise_i    (rise_det),
    .fall_i    (fall_det),
    .clr_i     (clr),
    .stat_o    (stat)
  );

  // Pad steering
  assign gpio_oe = claim_q & ~dir_q;
  assign pad_oe  = gpio_oe | (~claim_q & fn_oe);
  assign pad_out = (gpio_oe & lvl_q) | (~claim_q & fn_out);

  // Read port
  always_comb begin
    case (cfg_sel)
      SEL_CLAIM: cfg_rdata = claim_q;
      SEL_DIR:   cfg_rdata = dir_q;
      SEL_LEVEL: cfg_rdata = (dir_q & sync_in) | (~dir_q & lvl_q);
      SEL_RISE:  cfg_rdata = rise_q;
      SEL_FALL:  cfg_rdata = fall_q;
      SEL_STAT:  cfg_rdata = stat;
      SEL_WAKE:  cfg_rdata = wake_q;
      default:   cfg_rdata = '0;
    endcase
  end

  assign evt_o  = |stat;
  assign wake_o = |(stat & wake_q);

  AST_WAKE_NEEDS_EVT: assert property (@(posedge clk) disable iff (!rst_n_sync)
    wake_o |-> evt_o); // R12

  for (genvar i = 0; i < W; i++) begin : g_pad_chk
    AST_OE_ONLY_OUTPUT: assert property (@(posedge clk) disable iff (!rst_n_sync)
      (claim_q[i] && pad_oe[i]) |-> !dir_q[i]); // R4
    AST_NATIVE_OE: assert property (@(posedge clk) disable iff (!rst_n_sync)
      !claim_q[i] |-> (pad_oe[i] == fn_oe[i])); // R2
  end
endmodule

// File: tb/gpio_evt_bank_tb.sv
module gpio_evt_bank_tb;
  localparam int N = 8;
  localparam logic [N-1:0] STBY = 8'hF0;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         cfg_we;
  logic [2:0]   cfg_sel;
  logic [N-1:0] cfg_wdata, cfg_rdata, pad_in, fn_out, fn_oe, pad_out, pad_oe;
  logic         evt_o, wake_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #10 clk = ~clk;

  gpio_evt_bank #(.NUM_PINS(N), .STBY_PINS(STBY)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .pad_in(pad_in),
    .fn_out(fn_out), .fn_oe(fn_oe), .pad_out(pad_out), .pad_oe(pad_oe),
    .evt_o(evt_o), .wake_o(wake_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] sel, input logic [N-1:0] data);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] sel, output logic [N-1:0] data);
    @(negedge clk);
    cfg_sel = sel;
    #1 data = cfg_rdata;
  endtask

  task automatic drive_pad(input logic [N-1:0] v);
    @(negedge clk);
    pad_in = v;
    repeat (5) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [N-1:0] r;
    rst_n = 1'b0; cfg_we = 1'b0; cfg_sel = 3'd0; cfg_wdata = '0;
    pad_in = '0; fn_out = 8'hA5; fn_oe = 8'h3C;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state
    for (int s = 0; s < 7; s++) begin
      rd(3'(s), r);
      check("R1 reset vector", 32'(r), 32'h0);
    end
    check("R1 pad_out", 32'(pad_out), 32'hA5);
    check("R1 pad_oe", 32'(pad_oe), 32'h3C);
    check("R1 evt/wake", {30'd0, evt_o, wake_o}, 32'h0);

    // R2/R3/R4: pad steering under a partial claim
    wr(3'd0, 8'h33); wr(3'd1, 8'h0F); wr(3'd2, 8'h5A);
    #1;
    check("R2/R3/R4 pad_oe", 32'(pad_oe), 32'((8'h33 & ~8'h0F) | (~8'h33 & 8'h3C)));
    check("R2/R3/R4 pad_out", 32'(pad_out), 32'((8'h33 & ~8'h0F & 8'h5A) | (~8'h33 & 8'hA5)));
    wr(3'd0, 8'hFF);
    #1;
    check("R3/R4 full claim pad_oe", 32'(pad_oe), 32'hF0);
    check("R3/R4 full claim pad_out", 32'(pad_out), 32'h50);

    // R5: level readback mixes synchronized inputs and driven bits
    drive_pad(8'hC3);
    rd(3'd2, r);
    check("R5 level read", 32'(r), 32'((8'h0F & 8'hC3) | (~8'h0F & 8'h5A)));
    drive_pad(8'h00);

    // R12: wake-arm vector only holds standby pins
    wr(3'd6, 8'hFF);
    rd(3'd6, r);
    check("R12 wake mask", 32'(r), 32'(STBY));
    wr(3'd6, 8'h00);

    // R2 R6 R7 R8 R11: sweep every pin and every claim/dir/rise/fall combination
    for (int p = 0; p < N; p++) begin
      for (int c = 0; c < 16; c++) begin
        logic cl, dr, re, fe;
        logic [N-1:0] m;
        cl = c[3]; dr = c[2]; re = c[1]; fe = c[0];
        m = N'(1) << p;
        wr(3'd0, cl ? m : '0);
        wr(3'd1, dr ? m : '0);
        wr(3'd3, re ? m : '0);
        wr(3'd4, fe ? m : '0);
        wr(3'd5, '1);
        drive_pad(m);
        rd(3'd5, r);
        check("R2/R6/R8 rise status", 32'(r), 32'((cl & dr & re) ? m : '0));
        check("R11 evt after rise", {31'd0, evt_o}, {31'd0, cl & dr & re});
        wr(3'd5, '1);
        drive_pad('0);
        rd(3'd5, r);
        check("R2/R7/R8 fall status", 32'(r), 32'((cl & dr & fe) ? m : '0));
        check("R11 evt after fall", {31'd0, evt_o}, {31'd0, cl & dr & fe});
        wr(3'd5, '1);
      end
    end

    // R9: write-0 keeps, write-1 clears
    wr(3'd0, 8'hFF); wr(3'd1, 8'hFF); wr(3'd3, 8'hFF); wr(3'd4, 8'hFF);
    wr(3'd5, '1);
    drive_pad(8'h01);
    wr(3'd5, 8'h00);
    rd(3'd5, r);
    check("R9 write zero keeps", 32'(r), 32'h01);
    wr(3'd5, 8'h01);
    rd(3'd5, r);
    check("R9 write one clears", 32'(r), 32'h00);
    check("R11 evt low when clear", {31'd0, evt_o}, 32'h0);

    // R10: falling transition detected in the same cycle as a clear write
    drive_pad(8'h00);
    drive_pad(8'h01);
    rd(3'd5, r);
    check("R10 status preset", 32'(r), 32'h01);
    @(negedge clk);
    pad_in = 8'h00;
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = 3'd5; cfg_wdata = 8'h01;
    @(negedge clk);
    cfg_we = 1'b0;
    rd(3'd5, r);
    check("R10 set beats clear", 32'(r), 32'h01);
    wr(3'd5, '1);

    // R12: wake follows only standby pins with wake-arm set
    wr(3'd6, 8'hFF);
    drive_pad(8'h02);
    check("R12 non-standby no wake", {30'd0, evt_o, wake_o}, 32'h2);
    drive_pad(8'h22);
    check("R12 standby wake", {30'd0, evt_o, wake_o}, 32'h3);
    wr(3'd5, 8'h20);
    #1;
    check("R12 wake drops on clear", {30'd0, evt_o, wake_o}, 32'h2);

    finish_run();
  end
endmodule